// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker and Display Bus Packer

This block sits between a linear framebuffer fetch engine and a display timing pipeline. It accepts one 32-bit memory word per cycle, with a source-format code and a bus-format code that both travel with the word. It splits each word into pixels and widens narrow colour fields to 8 bits. It then emits each pixel formatted for the selected display bus, along with a flag that tells the next stage whether the pixel holds RGB or luma/chroma samples.

A word produces at most two pixels, so the output has two pixel lanes with a valid mask. Lane 0 always holds the earlier pixel. A line-start marker on the first word of a scan line clears the 24 bpp byte residue and restarts chroma alternation for the interleaved luma/chroma bus. The path has two register stages: an unpack stage and a bus-pack stage.

Top module: `pix_unpack_pack`

## Requirements
- R1: While reset is high and on the first cycle after it, `pix_vld` is 00 and `fmt_err` is 0.
- R2: Source code 0 (5-6-5 RGB, 16 bpp) yields two pixels per word. The low halfword is lane 0. Red is taken from bits 15:11, green from 10:5 and blue from 4:0. Each field is widened by appending its top bits, so a 5-bit field x becomes {x, x[4:2]} and a 6-bit field becomes {x, x[5:4]}. Lane 1 is never valid unless lane 0 is.
- R3: Source code 2 (1-5-5-5) takes red, green and blue from bits 14:10, 9:5 and 4:0. Source code 3 (4-4-4-4) takes them from bits 11:8, 7:4 and 3:0 and widens each nibble n to {n,n}. The top alpha bits have no effect.
- R4: Source code 5 yields one pixel per word, with red from bits 23:16, green from 15:8 and blue from 7:0. Source code 4 yields red from 7:0, green from 15:8 and blue from 23:16. Bits 31:24 are ignored in both.
- R5: Source code 1 (24 bpp, packed little-endian, blue byte first in memory) yields one, one and two pixels on three consecutive words. A word marked line-start begins with no residue.
- R6: Source codes 8 to 11 are 4:2:2 orders, listed from byte 0 (bits 7:0) upward. Code 8 is Y0 Cb Y1 Cr, code 9 is Y0 Cr Y1 Cb, code 10 is Cb Y0 Cr Y1 and code 11 is Cr Y0 Cb Y1. Each word gives two pixels {Y0,Cb,Cr} and {Y1,Cb,Cr}.
- R7: `pix_is_ycc` is 1 for source codes 8 to 11 and 0 for all others.
- R8: A pixel is the triple {c0,c1,c2}, meaning R,G,B or Y,Cb,Cr. Bus code 1 outputs {c0,c1,c2}. Bus code 0 outputs {8'h00, c0[7:3], c1[7:2], c2[7:3]}. Bus code 3 outputs zero.
- R9: Bus code 2 outputs {8'h00, chroma, c0}, where chroma is c1 on even pixels and c2 on odd pixels. Pixels are counted across words, and the count restarts at 0 on a line-start word.
- R10: Codes 6, 7 and 12 to 15 yield a single black pixel on lane 0 and set `fmt_err`. The flag stays set until reset.
- R11: Outputs for a word appear exactly two clock edges after the edge that accepts it. `pix_vld` is 00 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Word present this cycle |
| line_sol | input | 1 | Word is the first of a scan line |
| src_fmt | input | 4 | Source pixel format code |
| bus_fmt | input | 2 | Output bus format code |
| word_data | input | 32 | Framebuffer word, byte 0 in bits 7:0 |
| pix_vld | output | 2 | Lane valid mask |
| pix_bus0 | output | 24 | Lane 0 bus word |
| pix_bus1 | output | 24 | Lane 1 bus word |
| pix_is_ycc | output | 1 | Pixels carry luma/chroma |
| fmt_err | output | 1 | Sticky unknown-format flag |

## Verification
The assertions assume that `src_fmt` and `bus_fmt` are only meaningful in a cycle where `word_vld` is high, and that they are sampled together with the word. They also assume that a 24 bpp line is delivered as whole word groups, with no format change in the middle of a group unless line-start is raised. The stimulus sends one word at a time and holds every input at zero between words. It raises line-start at the start of each 24 bpp and interleaved-bus sequence, so residue and chroma phase are always in a known state when a check samples them.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    localparam int CW     = 8;
    localparam int WORD_W = 32;
    localparam int LANES  = 2;
    localparam int BUS_W  = 3 * CW;
    localparam int HALF_W = WORD_W / 2;

    typedef logic [CW-1:0] comp_t;

    typedef struct packed {
        comp_t c0;   // R or Y
        comp_t c1;   // G or Cb
        comp_t c2;   // B or Cr
    } pix_t;

    typedef enum logic [3:0] {
        SRC_RGB565   = 4'd0,
        SRC_RGB888   = 4'd1,
        SRC_ARGB1555 = 4'd2,
        SRC_ARGB4444 = 4'd3,
        SRC_ABGR8888 = 4'd4,
        SRC_ARGB8888 = 4'd5,
        SRC_YCBYCR   = 4'd8,
        SRC_YCRYCB   = 4'd9,
        SRC_CBYCRY   = 4'd10,
        SRC_CRYCBY   = 4'd11
    } src_fmt_e;

    typedef enum logic [1:0] {
        BUS_RGB16 = 2'd0,
        BUS_RGB24 = 2'd1,
        BUS_YC16  = 2'd2,
        BUS_NONE  = 2'd3
    } bus_fmt_e;

    typedef struct packed {
        logic [LANES-1:0] vld;
        pix_t             p0;
        pix_t             p1;
        logic             ycc;
        logic             sol;
        bus_fmt_e         bus;
    } stage_t;

    function automatic comp_t widen5(input logic [4:0] f);
        return {f, f[4:2]};
    endfunction

    function automatic comp_t widen6(input logic [5:0] f);
        return {f, f[5:4]};
    endfunction

    function automatic comp_t widen4(input logic [3:0] f);
        return {f, f};
    endfunction

    function automatic pix_t unpack16(input logic [3:0] fmt, input logic [HALF_W-1:0] v);
        pix_t p;
        case (fmt)
            SRC_ARGB1555: begin
                p.c0 = widen5(v[14:10]);
                p.c1 = widen5(v[9:5]);
                p.c2 = widen5(v[4:0]);
            end
            SRC_ARGB4444: begin
                p.c0 = widen4(v[11:8]);
                p.c1 = widen4(v[7:4]);
                p.c2 = widen4(v[3:0]);
            end
            default: begin
                p.c0 = widen5(v[15:11]);
                p.c1 = widen6(v[10:5]);
                p.c2 = widen5(v[4:0]);
            end
        endcase
        return p;
    endfunction

    function automatic logic [BUS_W-1:0] pack_bus(input pix_t p, input bus_fmt_e b,
                                                  input logic odd);
        case (b)
            BUS_RGB24: return {p.c0, p.c1, p.c2};
            BUS_RGB16: return {8'h00, p.c0[7:3], p.c1[7:2], p.c2[7:3]};
            BUS_YC16:  return {8'h00, (odd ? p.c2 : p.c1), p.c0};
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/pxu_unpack.sv
module pxu_unpack
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              in_sol,
    input  logic [3:0]        in_fmt,
    input  logic [1:0]        in_bus,
    input  logic [WORD_W-1:0] in_word,
    output stage_t            st_q,
    output logic              err_q
);
    localparam int RES_W = 2 * CW;

    logic [1:0]       res_cnt_q, res_cnt_d, eff_cnt;
    logic [RES_W-1:0] res_q, res_d;
    stage_t           st_d;
    logic             bad;
    comp_t            b [4];
    comp_t            y0, y1, ch_a, ch_b, cb, cr;

    for (genvar i = 0; i < 4; i++) begin : g_bytes
        assign b[i] = in_word[i*CW +: CW];
    end

    assign eff_cnt = in_sol ? 2'd0 : res_cnt_q;

    // Luma in even bytes when bit 1 of the code is clear; bit 0 swaps chroma
    always_comb begin
        if (!in_fmt[1]) begin
            y0 = b[0]; y1 = b[2]; ch_a = b[1]; ch_b = b[3];
        end else begin
            y0 = b[1]; y1 = b[3]; ch_a = b[0]; ch_b = b[2];
        end
        cb = in_fmt[0] ? ch_b : ch_a;
        cr = in_fmt[0] ? ch_a : ch_b;
    end

    always_comb begin
        st_d      = '0;
        st_d.sol  = in_sol;
        st_d.bus  = bus_fmt_e'(in_bus);
        res_cnt_d = res_cnt_q;
        res_d     = res_q;
        bad       = 1'b0;
        case (in_fmt)
            SRC_RGB565, SRC_ARGB1555, SRC_ARGB4444: begin
                st_d.p0  = unpack16(in_fmt, in_word[HALF_W-1:0]);
                st_d.p1  = unpack16(in_fmt, in_word[WORD_W-1:HALF_W]);
                st_d.vld = 2'b11;
            end
            SRC_RGB888: begin
                case (eff_cnt)
                    2'd0: begin
                        st_d.p0   = pix_t'(in_word[23:0]);
                        st_d.vld  = 2'b01;
                        res_cnt_d = 2'd1;
                        res_d     = {8'h00, in_word[31:24]};
                    end
                    2'd1: begin
                        st_d.p0   = pix_t'({in_word[15:0], res_q[7:0]});
                        st_d.vld  = 2'b01;
                        res_cnt_d = 2'd2;
                        res_d     = in_word[31:16];
                    end
                    default: begin
                        st_d.p0   = pix_t'({in_word[7:0], res_q});
                        st_d.p1   = pix_t'(in_word[31:8]);
                        st_d.vld  = 2'b11;
                        res_cnt_d = 2'd0;
                        res_d     = '0;
                    end
                endcase
            end
            SRC_ARGB8888: begin
                st_d.p0  = '{c0: b[2], c1: b[1], c2: b[0]};
                st_d.vld = 2'b01;
            end
            SRC_ABGR8888: begin
                st_d.p0  = '{c0: b[0], c1: b[1], c2: b[2]};
                st_d.vld = 2'b01;
            end
            SRC_YCBYCR, SRC_YCRYCB, SRC_CBYCRY, SRC_CRYCBY: begin
                st_d.p0  = '{c0: y0, c1: cb, c2: cr};
                st_d.p1  = '{c0: y1, c1: cb, c2: cr};
                st_d.vld = 2'b11;
                st_d.ycc = 1'b1;
            end
            default: begin
                st_d.vld = 2'b01;
                bad      = 1'b1;
            end
        endcase
        if (!in_vld) st_d.vld = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            err_q     <= 1'b0;
            res_cnt_q <= '0;
            res_q     <= '0;
        end else begin
            st_q  <= st_d;
            err_q <= err_q | (in_vld & bad);
            if (in_vld && in_fmt == SRC_RGB888) begin
                res_cnt_q <= res_cnt_d;
                res_q     <= res_d;
            end
        end
    end
endmodule

// File: rtl/pxu_buspack.sv
module pxu_buspack
    import pxu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stage_t           st,
    output logic [LANES-1:0] o_vld,
    output logic [BUS_W-1:0] o_bus0,
    output logic [BUS_W-1:0] o_bus1,
    output logic             o_ycc
);
    logic phase_q, ph0, ph_next;

    assign ph0     = st.sol ? 1'b0 : phase_q;
    // two pixels keep the parity, one pixel flips it
    assign ph_next = (st.vld == 2'b11) ? ph0 : ~ph0;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            o_vld   <= '0;
            o_bus0  <= '0;
            o_bus1  <= '0;
            o_ycc   <= 1'b0;
        end else begin
            o_vld <= st.vld;
            o_ycc <= st.ycc;
            if (st.vld != '0) begin
                phase_q <= ph_next;
                o_bus0  <= pack_bus(st.p0, st.bus, ph0);
                o_bus1  <= pack_bus(st.p1, st.bus, ~ph0);
            end
        end
    end
endmodule

// File: rtl/pix_unpack_pack.sv
module pix_unpack_pack
    import pxu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  word_vld,
    input  logic                  line_sol,
    input  logic [3:0]            src_fmt,
    input  logic [1:0]            bus_fmt,
    input  logic [WORD_W-1:0]     word_data,
    output logic [LANES-1:0]      pix_vld,
    output logic [BUS_W-1:0]      pix_bus0,
    output logic [BUS_W-1:0]      pix_bus1,
    output logic                  pix_is_ycc,
    output logic                  fmt_err
);
    stage_t stage;

    pxu_unpack u_unpack (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (word_vld),
        .in_sol  (line_sol),
        .in_fmt  (src_fmt),
        .in_bus  (bus_fmt),
        .in_word (word_data),
        .st_q    (stage),
        .err_q   (fmt_err)
    );

    pxu_buspack u_pack (
        .clk    (clk),
        .rst    (rst),
        .st     (stage),
        .o_vld  (pix_vld),
        .o_bus0 (pix_bus0),
        .o_bus1 (pix_bus1),
        .o_ycc  (pix_is_ycc)
    );
endmodule

// File: rtl/pxu_chk.sv
module pxu_chk (
    input logic        clk,
    input logic        rst,
    input logic        word_vld,
    input logic [3:0]  src_fmt,
    input logic [1:0]  bus_fmt,
    input logic [1:0]  pix_vld,
    input logic [23:0] pix_bus0,
    input logic [23:0] pix_bus1,
    input logic        pix_is_ycc,
    input logic        fmt_err
);
    logic       v1, v2;
    logic [3:0] f1, f2;
    logic [1:0] b1, b2;
    logic       known;

    assign known = (src_fmt <= 4'd5) || (src_fmt >= 4'd8 && src_fmt <= 4'd11);

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; v2 <= 1'b0;
            f1 <= '0;   f2 <= '0;
            b1 <= '0;   b2 <= '0;
        end else begin
            v1 <= word_vld; v2 <= v1;
            f1 <= src_fmt;  f2 <= f1;
            b1 <= bus_fmt;  b2 <= b1;
        end
    end

    assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
        ((pix_vld != 2'b00) == v2));

    assert_lane_order_R2: assert property (@(posedge clk) disable iff (rst)
        pix_vld != 2'b10);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        fmt_err |=> fmt_err);

    assert_err_set_R10: assert property (@(posedge clk) disable iff (rst)
        (word_vld && !known) |=> fmt_err);

    assert_ycc_src_R7: assert property (@(posedge clk) disable iff (rst)
        (pix_vld != 2'b00 && pix_is_ycc) |-> (f2 >= 4'd8 && f2 <= 4'd11));

    assert_narrow_bus_R8: assert property (@(posedge clk) disable iff (rst)
        (pix_vld != 2'b00 && b2 != 2'd1) |-> (pix_bus0[23:16] == 8'h00 && pix_bus1[23:16] == 8'h00));
endmodule

bind pix_unpack_pack pxu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_vld   (word_vld),
    .src_fmt    (src_fmt),
    .bus_fmt    (bus_fmt),
    .pix_vld    (pix_vld),
    .pix_bus0   (pix_bus0),
    .pix_bus1   (pix_bus1),
    .pix_is_ycc (pix_is_ycc),
    .fmt_err    (fmt_err)
);

// File: tb/tb_pix_unpack_pack.sv
module tb_pix_unpack_pack;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  fmt;
        logic [1:0]  bus;
        logic        sol;
        logic [31:0] word;
        logic [1:0]  vld;
        logic [23:0] e0;
        logic [23:0] e1;
        logic        ycc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{4'd0, 2'd1, 1'b0, 32'hF800_07E0, 2'b11, 24'h00FF00, 24'hFF0000, 1'b0, 4'd2}, // R2
        '{4'd0, 2'd1, 1'b0, 32'h001F_8410, 2'b11, 24'h848284, 24'h0000FF, 1'b0, 4'd2}, // R2
        '{4'd2, 2'd1, 1'b0, 32'h8000_7C00, 2'b11, 24'hFF0000, 24'h000000, 1'b0, 4'd3}, // R3
        '{4'd3, 2'd1, 1'b0, 32'h0ABC_F123, 2'b11, 24'h112233, 24'hAABBCC, 1'b0, 4'd3}, // R3
        '{4'd5, 2'd1, 1'b0, 32'hAA11_2233, 2'b01, 24'h112233, 24'h000000, 1'b0, 4'd4}, // R4
        '{4'd4, 2'd1, 1'b0, 32'hAA11_2233, 2'b01, 24'h332211, 24'h000000, 1'b0, 4'd4}, // R4
        '{4'd1, 2'd1, 1'b1, 32'h4433_2211, 2'b01, 24'h332211, 24'h000000, 1'b0, 4'd5}, // R5
        '{4'd1, 2'd1, 1'b0, 32'h8877_6655, 2'b01, 24'h665544, 24'h000000, 1'b0, 4'd5}, // R5
        '{4'd1, 2'd1, 1'b0, 32'hCCBB_AA99, 2'b11, 24'h998877, 24'hCCBBAA, 1'b0, 4'd5}, // R5
        '{4'd1, 2'd1, 1'b1, 32'h4433_2211, 2'b01, 24'h332211, 24'h000000, 1'b0, 4'd5}, // R5
        '{4'd1, 2'd1, 1'b1, 32'h0066_5544, 2'b01, 24'h665544, 24'h000000, 1'b0, 4'd5}, // R5 residue dropped
        '{4'd8, 2'd1, 1'b0, 32'h4030_2010, 2'b11, 24'h102040, 24'h302040, 1'b1, 4'd6}, // R6
        '{4'd9, 2'd1, 1'b0, 32'h4030_2010, 2'b11, 24'h104020, 24'h304020, 1'b1, 4'd6}, // R6
        '{4'd10,2'd1, 1'b0, 32'h4030_2010, 2'b11, 24'h201030, 24'h401030, 1'b1, 4'd6}, // R6
        '{4'd11,2'd1, 1'b0, 32'h4030_2010, 2'b11, 24'h203010, 24'h403010, 1'b1, 4'd7}, // R6 R7
        '{4'd5, 2'd0, 1'b0, 32'h00FF_8040, 2'b01, 24'h00FC08, 24'h000000, 1'b0, 4'd8}, // R8
        '{4'd5, 2'd3, 1'b0, 32'h0011_2233, 2'b01, 24'h000000, 24'h000000, 1'b0, 4'd8}, // R8
        '{4'd8, 2'd2, 1'b1, 32'h4030_2010, 2'b11, 24'h002010, 24'h004030, 1'b1, 4'd9}, // R9
        '{4'd8, 2'd2, 1'b0, 32'h4433_2211, 2'b11, 24'h002211, 24'h004433, 1'b1, 4'd9}, // R9
        '{4'd5, 2'd2, 1'b1, 32'h0011_2233, 2'b01, 24'h002211, 24'h000000, 1'b0, 4'd9}, // R9 even
        '{4'd5, 2'd2, 1'b0, 32'h0011_2233, 2'b01, 24'h003311, 24'h000000, 1'b0, 4'd9}, // R9 odd
        '{4'd5, 2'd2, 1'b1, 32'h0011_2233, 2'b01, 24'h002211, 24'h000000, 1'b0, 4'd9}, // R9 restart
        '{4'd6, 2'd1, 1'b0, 32'hFFFF_FFFF, 2'b01, 24'h000000, 24'h000000, 1'b0, 4'd10}, // R10
        '{4'd13,2'd1, 1'b0, 32'hFFFF_FFFF, 2'b01, 24'h000000, 24'h000000, 1'b0, 4'd10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_vld = 1'b0;
    logic        line_sol = 1'b0;
    logic [3:0]  src_fmt = '0;
    logic [1:0]  bus_fmt = '0;
    logic [31:0] word_data = '0;
    logic [1:0]  pix_vld;
    logic [23:0] pix_bus0, pix_bus1;
    logic        pix_is_ycc, fmt_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_unpack_pack dut (
        .clk        (clk),
        .rst        (rst),
        .word_vld   (word_vld),
        .line_sol   (line_sol),
        .src_fmt    (src_fmt),
        .bus_fmt    (bus_fmt),
        .word_data  (word_data),
        .pix_vld    (pix_vld),
        .pix_bus0   (pix_bus0),
        .pix_bus1   (pix_bus1),
        .pix_is_ycc (pix_is_ycc),
        .fmt_err    (fmt_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        word_vld  = 1'b1;
        line_sol  = v.sol;
        src_fmt   = v.fmt;
        bus_fmt   = v.bus;
        word_data = v.word;
        @(negedge clk);
        word_vld  = 1'b0;
        line_sol  = 1'b0;
        src_fmt   = '0;
        bus_fmt   = '0;
        word_data = '0;
        @(negedge clk);
        check($sformatf("R%0d vec%0d vld", v.req, idx), 32'(pix_vld), 32'(v.vld));
        if (v.vld[0]) check($sformatf("R%0d vec%0d lane0", v.req, idx), 32'(pix_bus0), 32'(v.e0));
        if (v.vld[1]) check($sformatf("R%0d vec%0d lane1", v.req, idx), 32'(pix_bus1), 32'(v.e1));
        check($sformatf("R%0d vec%0d ycc (R7)", v.req, idx), 32'(pix_is_ycc), 32'(v.ycc));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check("R1 vld in reset", 32'(pix_vld), 32'd0);
        check("R1 err in reset", 32'(fmt_err), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 vld after reset", 32'(pix_vld), 32'd0);
        check("R1 err after reset", 32'(fmt_err), 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(TBL[i], i);
            if (i == 21) check("R10 err clear before bad code", 32'(fmt_err), 32'd0);
        end

        // R11: no output in the cycle after the word's result
        @(negedge clk);
        check("R11 idle vld", 32'(pix_vld), 32'd0);

        // R10: flag survives a later valid word
        run_vec('{4'd5, 2'd1, 1'b0, 32'h0001_0203, 2'b01, 24'h010203, 24'h0, 1'b0, 4'd4}, 99);
        check("R10 err sticky", 32'(fmt_err), 32'd1);

        // R1: reset clears the flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 err cleared by reset", 32'(fmt_err), 32'd0);
        check("R1 vld cleared by reset", 32'(pix_vld), 32'd0);

        // R5: after reset the first 24 bpp word has no residue
        run_vec('{4'd1, 2'd1, 1'b0, 32'h0033_2211, 2'b01, 24'h332211, 24'h0, 1'b0, 4'd5}, 100);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule